// File: doc/BRIEF.md
# Programmable Parallel PRBS Word Generator

This block is an on-chip source of pseudorandom test patterns. On every enabled clock it puts out a 16-bit word. Each word carries the next sixteen consecutive bits of a maximal-length binary sequence, so a serializer placed after it can send a continuous pattern. A 3-bit mode input picks one of five sequence lengths: 2^7−1, 2^10−1, 2^15−1, 2^23−1 or 2^31−1 bits. These are the usual pseudorandom lengths used for telecom link testing.

A single 31-bit shift-register state serves all five polynomials. Each mode uses only the low-order bits it needs. The next state is not reached by shifting one bit per clock. Combinational parallel feedback advances it sixteen sequence steps in one cycle, so the block runs at the word rate and needs no bit-rate clock.

Reset, and any change of the mode input, seed the register with all ones. This keeps the generator out of the all-zero lock-up state. A valid flag marks the cycles in which a freshly generated word is present.

Top module: `prbs_word_gen`

## Requirements
- R1: Mode codes select the sequence as follows. Code 0 gives x^7+x^6+1, code 1 gives x^10+x^7+1, code 2 gives x^15+x^14+1, code 3 gives x^23+x^18+1, and codes 4 to 7 give x^31+x^28+1. For degree n and middle tap k, the sequence obeys b[t] = b[t−n] XOR b[t−k].
- R2: Each enabled advance emits the next 16 consecutive sequence bits. Bit 15 of the word is the earliest bit in time and bit 0 is the latest.
- R3: While reset is high at a clock edge, the valid flag and the word are cleared to zero and the mode is captured. The register is seeded so that the n bits preceding the first output bit are all ones.
- R4: At a clock edge where the mode input differs from the held mode, the new mode is taken and the register is reseeded as in R3. Valid is low for that one cycle and the word keeps its value. This takes priority over enable.
- R5: At a clock edge with enable low and no mode change, the word, the valid flag and the sequence position all hold.
- R6: At a clock edge with enable high and no mode change, the word is updated and valid is high after that edge.
- R7: The shift-register state is never all zero, and the state bits above the selected degree stay zero.
- R8: The output sequence is maximal length. It repeats after exactly 2^n−1 bits, and within one period the all-ones n-bit window occurs exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Sequence length select, encoded as in R1 |
| en_i | input | 1 | Advance the sequence by one word when high |
| word_o | output | 16 | Output word, bit 15 earliest in the sequence |
| valid_o | output | 1 | High when word_o holds a newly generated word |

## Verification
A mode change and an enabled advance can fall on the same clock edge, and the mode change must win. It reseeds the register, drops valid for that cycle and leaves the word unchanged. The bench provokes this with directed cases that switch the mode with enable high and with enable low. It also does so inside a random phase that changes the mode at random moments while enable toggles. A bench model computes the expected word and flag after every edge from a serial history recurrence and judges the outcome against it. Separate long runs in the 7-bit and 10-bit modes record the output bit stream and check its exact period.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int STATE_W = 31;
  localparam int MODE_W  = 3;
  localparam int POS_W   = 5;

  // Highest used state bit (degree minus one) for a mode code
  function automatic logic [POS_W-1:0] top_pos(input logic [MODE_W-1:0] m);
    case (m)
      3'd0:    return 5'd6;
      3'd1:    return 5'd9;
      3'd2:    return 5'd14;
      3'd3:    return 5'd22;
      default: return 5'd30;
    endcase
  endfunction

  // Middle feedback tap position (tap exponent minus one)
  function automatic logic [POS_W-1:0] tap_pos(input logic [MODE_W-1:0] m);
    case (m)
      3'd0:    return 5'd5;
      3'd1:    return 5'd6;
      3'd2:    return 5'd13;
      3'd3:    return 5'd17;
      default: return 5'd27;
    endcase
  endfunction

  // Mask of the state bits used by a mode; also the all-ones seed
  function automatic logic [STATE_W-1:0] used_mask(input logic [MODE_W-1:0] m);
    logic [5:0]  width;
    logic [31:0] full;
    width = {1'b0, top_pos(m)} + 6'd1;
    full  = (32'd1 << width) - 32'd1;
    return full[STATE_W-1:0];
  endfunction

  // One serial step: bit 0 receives the newest sequence bit
  function automatic logic [STATE_W-1:0] adv_one(input logic [STATE_W-1:0] s,
                                                  input logic [MODE_W-1:0]  m);
    logic fb;
    fb = s[top_pos(m)] ^ s[tap_pos(m)];
    return {s[STATE_W-2:0], fb} & used_mask(m);
  endfunction

endpackage

// File: rtl/prbs_mode_track.sv
module prbs_mode_track
  import prbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_q,
  output logic              mode_chg
);

  always_ff @(posedge clk) begin
    if (rst || mode_chg) mode_q <= mode_i;
  end

  // Event wire: the sampled select differs from the one in use
  assign mode_chg = (mode_i != mode_q);

  a_r4_mode_taken: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (mode_q == $past(mode_i)));

endmodule

// File: rtl/prbs_step_net.sv
module prbs_step_net
  import prbs_pkg::*;
#(
  parameter int STEPS = 16
)(
  input  logic [STATE_W-1:0] state_i,
  input  logic [MODE_W-1:0]  mode_i,
  output logic [STATE_W-1:0] state_o,
  output logic [STEPS-1:0]   bits_o
);

  logic [STATE_W-1:0] chain [0:STEPS];

  assign chain[0] = state_i;

  // Unrolled look-ahead: step g yields the g-th bit in time order
  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1]          = adv_one(chain[g], mode_i);
    assign bits_o[STEPS-1-g]   = chain[g+1][0];
  end

  assign state_o = chain[STEPS];

endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_pkg::*;
#(
  parameter int WORD_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  logic [MODE_W-1:0]  mode_q;
  logic               mode_chg;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_nx;
  logic [WORD_W-1:0]  bits_nx;
  logic               adv_ev;
  logic               reseed_ev;

  prbs_mode_track u_mode (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .mode_q   (mode_q),
    .mode_chg (mode_chg)
  );

  prbs_step_net #(.STEPS(WORD_W)) u_net (
    .state_i (state_q),
    .mode_i  (mode_q),
    .state_o (state_nx),
    .bits_o  (bits_nx)
  );

  // Named events for the checks below
  assign reseed_ev = rst || mode_chg;
  assign adv_ev    = en_i && !reseed_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= used_mask(mode_i);
      word_o  <= '0;
      valid_o <= 1'b0;
    end else if (mode_chg) begin
      state_q <= used_mask(mode_i);
      valid_o <= 1'b0;
    end else if (en_i) begin
      state_q <= state_nx;
      word_o  <= bits_nx;
      valid_o <= 1'b1;
    end
  end

  a_r4_reseed: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!valid_o && $stable(word_o) && state_q == used_mask(mode_q)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !mode_chg) |=> ($stable(word_o) && $stable(valid_o) && $stable(state_q)));

  a_r6_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    adv_ev |=> valid_o);

  a_r7_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  a_r7_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (state_q & ~used_mask(mode_q)) == '0);

endmodule

// File: tb/sim_prbs_word_gen.sv
module sim_prbs_word_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic        en;
  logic [15:0] word_o;
  logic        valid_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prbs_word_gen u0 (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode),
    .en_i    (en),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  // Bench model state
  logic [2:0]  m_mode;
  logic [63:0] hist;        // hist[j] = sequence bit j+1 steps in the past
  logic [15:0] m_word;
  logic        m_valid;
  bit          armed = 0;
  string       tag = "R3";

  // Capture buffer for the period check
  bit          cap_on = 0;
  int          cap_n  = 0;
  logic        cap [0:2303];

  function automatic int deg_of(input logic [2:0] m);
    case (m)
      3'd0: return 7;
      3'd1: return 10;
      3'd2: return 15;
      3'd3: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int mid_of(input logic [2:0] m);
    case (m)
      3'd0: return 6;
      3'd1: return 7;
      3'd2: return 14;
      3'd3: return 18;
      default: return 28;
    endcase
  endfunction

  task automatic check(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // Model of one clock edge, from the requirements
  task automatic model_edge(input logic r, input logic [2:0] m, input logic e);
    if (r) begin
      m_mode = m; hist = '1; m_word = '0; m_valid = 1'b0;
    end else if (m != m_mode) begin
      m_mode = m; hist = '1; m_valid = 1'b0;
    end else if (e) begin
      for (int i = 0; i < 16; i++) begin
        logic nb;
        nb = hist[deg_of(m_mode)-1] ^ hist[mid_of(m_mode)-1];
        hist = {hist[62:0], nb};
        m_word[15-i] = nb;
        if (cap_on && cap_n < 2304) begin
          cap[cap_n] = nb;
          cap_n++;
        end
      end
      m_valid = 1'b1;
    end
  endtask

  task automatic cyc(input logic r, input logic [2:0] m, input logic e);
    @(negedge clk);
    if (armed) begin
      check(tag, "valid", {31'd0, valid_o}, {31'd0, m_valid});
      check(tag, "word", {16'd0, word_o}, {16'd0, m_word});
    end
    rst = r; mode = m; en = e;
    model_edge(r, m, e);
    armed = 1;
  endtask

  task automatic period_check(input string t, input int n);
    int p;
    int ones_win;
    bit ok;
    p = (1 << n) - 1;
    ok = (cap_n >= 2*p + n);
    check(t, "captured enough bits", {31'd0, ok}, 32'd1);
    if (ok) begin
      int bad = 0;
      for (int i = 0; i < p + n; i++)
        if (cap[i] !== cap[i+p]) bad++;
      check(t, "mismatches at period shift", bad, 0);
      ones_win = 0;
      for (int i = 0; i < p; i++) begin
        bit all1 = 1;
        for (int j = 0; j < n; j++) if (cap[i+j] !== 1'b1) all1 = 0;
        if (all1) ones_win++;
      end
      check(t, "all-ones windows per period", ones_win, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; mode = 3'd0; en = 1'b0;

    // R3: reset state
    tag = "R3";
    cyc(1, 3'd0, 0);
    cyc(1, 3'd0, 1);
    cyc(0, 3'd0, 0);

    // R1 R2 R5 R6: every mode with random enable
    for (int md = 0; md < 5; md++) begin
      tag = "R1_R2_R5_R6";
      cyc(0, 3'(md), 0);
      for (int c = 0; c < 250; c++)
        cyc(0, 3'(md), ($urandom_range(0, 99) < 80));
    end

    // R4: mode change together with enable high, then with enable low
    tag = "R4";
    cyc(0, 3'd2, 1);
    cyc(0, 3'd2, 1);
    cyc(0, 3'd1, 1);
    cyc(0, 3'd1, 1);
    cyc(0, 3'd3, 0);
    cyc(0, 3'd3, 0);
    cyc(0, 3'd3, 1);
    // reserved codes act as the 31-bit mode but still reseed on change
    tag = "R1_R4";
    cyc(0, 3'd6, 1);
    for (int c = 0; c < 20; c++) cyc(0, 3'd6, 1);
    cyc(0, 3'd7, 1);
    for (int c = 0; c < 20; c++) cyc(0, 3'd7, 1);

    // R4 R5 R6: random mode switches mixed with random enable
    tag = "R4_R5_R6_R7";
    for (int c = 0; c < 600; c++) begin
      logic [2:0] nm = mode;
      if ($urandom_range(0, 99) < 6) nm = 3'($urandom_range(0, 7));
      cyc(0, nm, ($urandom_range(0, 99) < 70));
    end

    // R3: reset in the middle of a run
    tag = "R3";
    cyc(1, 3'd4, 1);
    cyc(0, 3'd4, 1);
    cyc(0, 3'd4, 1);

    // R8: exact period, 7-bit mode
    tag = "R8";
    cyc(0, 3'd0, 0);
    cap_n = 0; cap_on = 1;
    for (int c = 0; c < 20; c++) cyc(0, 3'd0, 1);
    cap_on = 0;
    period_check("R8_mode7", 7);

    // R8: exact period, 10-bit mode
    cyc(0, 3'd1, 0);
    cap_n = 0; cap_on = 1;
    for (int c = 0; c < 140; c++) cyc(0, 3'd1, 1);
    cap_on = 0;
    period_check("R8_mode10", 10);

    cyc(0, 3'd1, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule